// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recently used page table entries so that most virtual-to-physical translations finish without a walk of the two-level page table. A request carries a 32-bit virtual address. The upper 20 bits form the virtual page number, which is a 10-bit directory index followed by a 10-bit table index. The low 12 bits are the offset within the page. The page number is compared against every stored entry in the same cycle. When one of them matches, the block returns a physical address built from the cached frame number and the unchanged offset. When none matches, it raises a miss, and the page table is not touched.

On a miss, an external walker resolves the translation and then writes the result back through the refill port. A refill fills the lowest free slot while one exists. Once every slot is valid, a refill replaces the slot named by a rotating victim pointer. A refill for a page that is already cached updates that entry in place. A flush input drops every entry at once. The number of entries is a parameter, intended to lie between 4 and 64.

Top module: `xlate_buf`

## Requirements
- R1: After reset no entry is valid: `lk_hit` and `lk_miss` are low, and the first lookup reports a miss.
- R2: A lookup whose page number (address bits 31:12) matches a valid entry raises `lk_hit` on the clock edge after the request. `lk_paddr` is then {stored 20-bit frame number, request bits 11:0}.
- R3: A lookup whose page number matches no valid entry raises `lk_miss` on the clock edge after the request, with `lk_paddr` equal to zero.
- R4: In a cycle that follows a cycle without `lk_req`, both `lk_hit` and `lk_miss` are low.
- R5: `lk_hit` and `lk_miss` are never high together.
- R6: While a free slot exists, a refill of a new page number takes a free slot and evicts nothing. Up to ENTRIES distinct refills into an empty buffer all stay resident.
- R7: A refill whose page number is already cached overwrites that entry's frame number. No second copy is made, no other entry is lost, and the victim pointer does not move.
- R8: When all slots are valid, a refill of a new page number replaces the slot at the victim pointer. The pointer starts at slot 0 after reset or flush, goes up by one after each such replacement, and wraps from ENTRIES-1 back to 0. Slots are filled in ascending order.
- R9: A flush invalidates every entry on the next edge and resets the victim pointer to 0. A refill in the same cycle as a flush is dropped.
- R10: Only address bits 31:12 take part in the match. Both the directory field (bits 31:22) and the table field (bits 21:12) must agree, and the offset bits never affect the outcome.
- R11: A lookup made in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Previous-cycle lookup found a translation |
| lk_miss | output | 1 | Previous-cycle lookup found none |
| lk_paddr | output | 32 | Translated physical address, zero unless `lk_hit` |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Page number of the refill entry |
| rf_pfn | input | 20 | Frame number of the refill entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer to exactly its capacity. A design that evicted before the buffer was full would lose one of those sixteen pages. It then refills a page that is already cached. A design that made a duplicate entry, or that advanced the pointer on an in-place update, would either return the old frame or evict the wrong page later. Replacement is followed through more than one full rotation, so a pointer that fails to wrap, or that starts at the wrong slot, shows up as a wrong page missing. Lookups that coincide with a refill must see the old contents. A refill that coincides with a flush must not survive the flush. Address pairs that differ only in the directory field, or only in the offset, expose a compare over the wrong bits.

// File: rtl/xlate_buf_pkg.sv
`timescale 1ns/1ps
package xlate_buf_pkg;
  localparam int unsigned XB_DIR_W  = 10;
  localparam int unsigned XB_TBL_W  = 10;
  localparam int unsigned XB_OFF_W  = 12;
  localparam int unsigned XB_PFN_W  = 20;
  localparam int unsigned XB_NENT   = 16;
endpackage

// File: rtl/xlate_buf_cam.sv
`timescale 1ns/1ps
// Parallel tag compare: one comparator per slot for the lookup key and
// one for the refill key.
module xlate_buf_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [VPN_W-1:0]              key_lk_i,
  input  logic [VPN_W-1:0]              key_rf_i,
  output logic [ENTRIES-1:0]            match_lk_o,
  output logic [ENTRIES-1:0]            match_rf_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match_lk_o[g] = vld_i[g] && (tag_i[g] == key_lk_i);
    assign match_rf_o[g] = vld_i[g] && (tag_i[g] == key_rf_i);
  end
endmodule

// File: rtl/xlate_buf_alloc.sv
`timescale 1ns/1ps
// Refill slot selection: in-place update, else lowest free slot, else
// the rotating victim.
module xlate_buf_alloc #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic [ENTRIES-1:0] dup_i,
  input  logic               rf_valid_i,
  input  logic               flush_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o
);
  logic [IDX_W-1:0] ptr_q, ptr_nxt;
  logic             ptr_en;
  logic             free_found, dup_found, evict;
  logic [IDX_W-1:0] free_idx, dup_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    dup_found  = 1'b0;
    dup_idx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (dup_i[i]) begin
        dup_found = 1'b1;
        dup_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    wr_en_o = rf_valid_i && !flush_i;
    evict   = 1'b0;
    if (dup_found) begin
      wr_idx_o = dup_idx;
    end else if (free_found) begin
      wr_idx_o = free_idx;
    end else begin
      wr_idx_o = ptr_q;
      evict    = 1'b1;
    end
  end

  always_comb begin
    ptr_en  = flush_i || (wr_en_o && evict);
    ptr_nxt = ptr_q;
    if (flush_i) begin
      ptr_nxt = '0;
    end else if (wr_en_o && evict) begin
      ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_nxt;
    end
  end

  // R8: every replacement moves the pointer on
  a_r8_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && evict) |=> (ptr_q != $past(ptr_q)));
  // R7: an in-place update leaves the pointer alone
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid_i && !flush_i && dup_found) |=> $stable(ptr_q));
endmodule

// File: rtl/xlate_buf.sv
`timescale 1ns/1ps
module xlate_buf
  import xlate_buf_pkg::*;
#(
  parameter int unsigned ENTRIES = XB_NENT,
  parameter int unsigned DIR_W   = XB_DIR_W,
  parameter int unsigned TBL_W   = XB_TBL_W,
  parameter int unsigned OFF_W   = XB_OFF_W,
  parameter int unsigned PFN_W   = XB_PFN_W,
  localparam int unsigned VPN_W  = DIR_W + TBL_W,
  localparam int unsigned VA_W   = VPN_W + OFF_W,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PFN_W-1:0] rf_pfn,
  input  logic             flush
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // entry storage
  logic [ENTRIES-1:0]            vld_q, vld_nxt;
  logic                          vld_en;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q, tag_nxt;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q, pfn_nxt;
  logic [ENTRIES-1:0]            match_lk, match_rf;
  logic                          wr_en;
  logic [IDX_W-1:0]              wr_idx;
  logic [VPN_W-1:0]              lk_vpn;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  xlate_buf_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
    .tag_i      (tag_q),
    .vld_i      (vld_q),
    .key_lk_i   (lk_vpn),
    .key_rf_i   (rf_vpn),
    .match_lk_o (match_lk),
    .match_rf_o (match_rf)
  );

  xlate_buf_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .vld_i      (vld_q),
    .dup_i      (match_rf),
    .rf_valid_i (rf_valid),
    .flush_i    (flush),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx)
  );

  always_comb begin
    vld_nxt = vld_q;
    tag_nxt = tag_q;
    pfn_nxt = pfn_q;
    vld_en  = flush || wr_en;
    if (flush) begin
      vld_nxt = '0;
    end else if (wr_en) begin
      vld_nxt[wr_idx] = 1'b1;
      tag_nxt[wr_idx] = rf_vpn;
      pfn_nxt[wr_idx] = rf_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= '0;
    end else if (vld_en) begin
      vld_q <= vld_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q <= tag_nxt;
      pfn_q <= pfn_nxt;
    end
  end

  // lookup response
  logic             hit_any;
  logic [PFN_W-1:0] sel_pfn;
  logic             hit_nxt, miss_nxt;
  logic [PA_W-1:0]  pa_nxt;

  always_comb begin
    sel_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_pfn = sel_pfn | (match_lk[i] ? pfn_q[i] : '0);
    end
    hit_any  = |match_lk;
    hit_nxt  = lk_req && hit_any;
    miss_nxt = lk_req && !hit_any;
    pa_nxt   = hit_nxt ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_hit   <= hit_nxt;
      lk_miss  <= miss_nxt;
      lk_paddr <= pa_nxt;
    end
  end

  // R5
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(lk_hit && lk_miss));
  // R4
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lk_req |=> (!lk_hit && !lk_miss));
  // R3
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_miss |-> (lk_paddr == '0));
  // R2
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
  // R7: no page is cached twice
  a_r7_no_dup: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(match_lk));
  // R9
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |=> (vld_q == '0));
  // R6: a new page into a non-full buffer adds exactly one valid slot
  a_r6_fill_grows: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rf_valid && !flush && !(|match_rf) && !(&vld_q))
      |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));
endmodule

// File: tb/xlate_buf_test.sv
`timescale 1ns/1ps
module xlate_buf_test;
  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic        rf_valid;
  logic [19:0] rf_vpn, rf_pfn;
  logic        flush;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  xlate_buf uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .flush(flush)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_refill(input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] va, input bit exp_hit,
                           input logic [31:0] exp_pa, input string rq);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_req = 1'b0;
    chk({rq, " hit"},  {31'd0, lk_hit},  {31'd0, exp_hit});
    chk({rq, " miss"}, {31'd0, lk_miss}, {31'd0, !exp_hit});
    chk({rq, " paddr"}, lk_paddr, exp_hit ? exp_pa : 32'd0);
    chk("R5 exclusive", {31'd0, lk_hit && lk_miss}, 32'd0);
  endtask

  task automatic do_flush(input bit with_refill, input logic [19:0] vpn);
    @(negedge clk);
    flush = 1'b1;
    rf_valid = with_refill; rf_vpn = vpn; rf_pfn = 20'hFFFFF;
    @(negedge clk);
    flush = 1'b0; rf_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hit low", {31'd0, lk_hit}, 32'd0);
    chk("R1 miss low", {31'd0, lk_miss}, 32'd0);
    do_lookup(32'h1234_5678, 1'b0, 32'd0, "R1 empty lookup");
  endtask

  task automatic t_hit_miss();
    do_refill(20'h12345, 20'hABCDE);
    do_lookup(32'h1234_5678, 1'b1, 32'hABCD_E678, "R2 hit");
    do_lookup(32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, "R10 offset ignored");
    do_lookup(32'h1234_6678, 1'b0, 32'd0, "R3 table field differs");
    do_lookup(32'h9234_5678, 1'b0, 32'd0, "R10 directory field differs");
  endtask

  task automatic t_idle();
    do_lookup(32'h1234_5000, 1'b1, 32'hABCD_E000, "R2 hit before idle");
    @(negedge clk);
    chk("R4 idle hit", {31'd0, lk_hit}, 32'd0);
    chk("R4 idle miss", {31'd0, lk_miss}, 32'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = 20'h00777; rf_pfn = 20'h00123;
    lk_req = 1'b1; lk_vaddr = 32'h0077_7ABC;
    @(negedge clk);
    rf_valid = 1'b0; lk_req = 1'b0;
    chk("R11 lookup sees old contents", {31'd0, lk_miss}, 32'd1);
    do_lookup(32'h0077_7ABC, 1'b1, 32'h0012_3ABC, "R11 later lookup hits");
  endtask

  task automatic t_flush();
    do_flush(1'b0, 20'h0);
    do_lookup(32'h1234_5678, 1'b0, 32'd0, "R9 flushed A");
    do_lookup(32'h0077_7000, 1'b0, 32'd0, "R9 flushed B");
    do_flush(1'b1, 20'h0BEEF);
    do_lookup(32'h0BEE_F000, 1'b0, 32'd0, "R9 refill dropped by flush");
  endtask

  task automatic t_fill();
    do_flush(1'b0, 20'h0);
    for (int i = 0; i < NENT; i++) do_refill(20'h00100 + 20'(i), 20'h50000 + 20'(i));
    for (int i = 0; i < NENT; i++)
      do_lookup({20'h00100 + 20'(i), 12'h0A0}, 1'b1, {20'h50000 + 20'(i), 12'h0A0},
                "R6 full fill resident");
  endtask

  task automatic t_dup();
    do_refill(20'h00105, 20'h7FFFF);
    do_lookup(32'h0010_5004, 1'b1, 32'h7FFF_F004, "R7 overwrite in place");
    for (int i = 0; i < NENT; i++)
      if (i != 5)
        do_lookup({20'h00100 + 20'(i), 12'h0}, 1'b1, {20'h50000 + 20'(i), 12'h0},
                  "R7 others kept");
  endtask

  task automatic t_evict();
    do_refill(20'h00400, 20'h60000);
    do_lookup(32'h0010_0000, 1'b0, 32'd0, "R8 slot 0 evicted first");
    do_lookup(32'h0040_0000, 1'b1, 32'h6000_0000, "R8 new entry present");
    do_lookup(32'h0010_1000, 1'b1, 32'h5000_1000, "R8 slot 1 kept");
    do_refill(20'h00401, 20'h60001);
    do_lookup(32'h0010_1000, 1'b0, 32'd0, "R8 slot 1 evicted second");
    do_lookup(32'h0010_2000, 1'b1, 32'h5000_2000, "R8 slot 2 kept");
    do_refill(20'h00402, 20'h60002);
    do_lookup(32'h0010_2000, 1'b0, 32'd0, "R7 pointer not moved by update");
    do_lookup(32'h0010_5000, 1'b1, 32'h7FFF_F000, "R8 updated entry kept");
  endtask

  task automatic t_wrap();
    do_flush(1'b0, 20'h0);
    for (int i = 0; i < NENT; i++) do_refill(20'h00200 + 20'(i), 20'h40000 + 20'(i));
    for (int k = 0; k <= NENT; k++) do_refill(20'h00300 + 20'(k), 20'h30000 + 20'(k));
    do_lookup(32'h0030_0000, 1'b0, 32'd0, "R8 wrap evicts slot 0 again");
    for (int k = 1; k <= NENT; k++)
      do_lookup({20'h00300 + 20'(k), 12'h0}, 1'b1, {20'h30000 + 20'(k), 12'h0},
                "R8 wrap survivors");
    for (int i = 0; i < NENT; i++)
      do_lookup({20'h00200 + 20'(i), 12'h0}, 1'b0, 32'd0, "R8 old set gone");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_vaddr = '0;
    rf_valid = 1'b0; rf_vpn = '0; rf_pfn = '0; flush = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit_miss();
    t_idle();
    t_same_cycle();
    t_flush();
    t_fill();
    t_dup();
    t_evict();
    t_wrap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule